// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial clock for a serial flash interface from the core clock. A divide value `div_n` sets the period to `div_n + 1` core cycles. A separate high-time value `high_cnt` sets how many of those cycles the line spends away from its resting level. When `bypass` is set, or when `div_n` is zero, the core clock itself is passed straight to the line.

A run gate decides whether a new clock period may start. Periods start only while `enable` is high, and then only while chip select is active, while a tail allowance is still left after chip select has dropped, or while free-running is selected. A period that has started always runs to its end, so the line never shows a shortened pulse. The resting level of the line can be programmed.

Two single-cycle strobes tell a neighbouring shifter, one core cycle ahead, that the line is about to leave its resting level (the sampling edge) or return to it (the launching edge). Settings are taken up only at period boundaries.

Top module: `sclk_gen`

## Requirements
- R1: Outside bypass and with `div_n` = N ≥ 1, the serial clock repeats every N+1 core cycles while it runs.
- R2: Each period starts with the line at the level opposite the idle level. It stays there for H+1 core cycles, where H is `high_cnt`, and spends the rest of the period at the idle level.
- R3: If `high_cnt` is greater than or equal to `div_n`, the high time is taken as `div_n`−1. Every period then still ends with at least one core cycle at the idle level.
- R4: When `bypass`=1 or `div_n`=0, a running line follows the core clock. It equals `clk` when the idle level is low and `~clk` when the idle level is high. Both strobes are 1 in every core cycle in which it runs.
- R5: Outside bypass, `sample_stb` is 1 in exactly the core cycles that are directly followed by the line leaving the idle level. `launch_stb` is 1 in exactly those directly followed by a return to the idle level. The two are never 1 together.
- R6: While no period runs, the line sits at the idle level: high when `idle_high`=1 and low when it is 0. During and right after reset the line is low and both strobes are 0.
- R7: `tail_mode` encodes what happens after chip select goes inactive. The period in progress always completes. Code 0 then stops the clock. Code 1 runs one more full period, code 2 runs two more, and code 3 keeps the clock running regardless of chip select.
- R8: Changes to `div_n`, `high_cnt` and `bypass` made during a period take effect from the next period boundary. `idle_high` is taken up only while no period runs.
- R9: Dropping `enable` prevents any new period from starting. The period in progress completes without being cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new clock periods to start |
| cs_active | input | 1 | Chip select asserted (active high) |
| tail_mode | input | 2 | Run-on policy after chip select drops: 0 none, 1 one period, 2 two periods, 3 free running |
| div_n | input | DIV_W | Period length minus one, in core cycles; 0 selects pass-through |
| high_cnt | input | DIV_W | Cycles at the non-idle level minus one |
| bypass | input | 1 | Pass the core clock straight to the line |
| idle_high | input | 1 | Idle level of the line: 1 high, 0 low |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | Next core edge returns the line to idle level |
| sample_stb | output | 1 | Next core edge moves the line off the idle level |

## Verification
The bench builds the block with its default 8-bit divide width. It keeps divide values between 1 and 12, which lets many whole periods and every tail code fit into a short run. Within that range, random divide and high-time pairs, the clamped high time, the one-cycle-high case at N=1, and both pass-through triggers (the bypass bit and a zero divide) are all reachable. It also covers both idle levels and a settings change in the middle of a period, which shows whether the old period length is kept until the boundary.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    // Run-on policy after chip select goes inactive
    typedef enum logic [1:0] {
        TAIL_NONE = 2'd0,
        TAIL_ONE  = 2'd1,
        TAIL_TWO  = 2'd2,
        TAIL_FREE = 2'd3
    } tail_mode_e;

    // Line output register state
    typedef struct packed {
        logic sclk;
        logic idle;
    } line_st_t;

endpackage

// File: rtl/sclk_run_gate.sv
module sclk_run_gate
    import sclk_gen_pkg::*;
#(
    parameter int TAIL_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cs_active,
    input  logic [1:0] tail_mode,
    input  logic       bnd,
    output logic       go
);

    typedef struct packed {
        logic [TAIL_W-1:0] tail;
    } gate_st_t;

    gate_st_t   st_d, st_q;
    tail_mode_e mode;

    always_comb begin
        mode = tail_mode_e'(tail_mode);
        go   = enable && (cs_active || (mode == TAIL_FREE) || (st_q.tail != '0));
        st_d = st_q;
        if (cs_active) begin
            st_d.tail = (mode == TAIL_FREE) ? '0 : TAIL_W'(tail_mode);
        end else if (bnd && go && (mode != TAIL_FREE) && (st_q.tail != '0)) begin
            st_d.tail = st_q.tail - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tail <= TAIL_W'(2)); // R7

    AST_TAIL_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && st_q.tail != '0) |=> (st_q.tail <= $past(st_q.tail))); // R7

endmodule

// File: rtl/sclk_period_cnt.sv
module sclk_period_cnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div_n,
    input  logic [DIV_W-1:0] high_cnt,
    input  logic             bypass,
    output logic             bnd,
    output logic             act_q,
    output logic             byp_q,
    output logic             act_d,
    output logic             byp_d,
    output logic             hi_d
);

    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    typedef struct packed {
        logic             act;
        logic             byp;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] n;
        logic [DIV_W-1:0] h;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             byp_eff;
    logic [DIV_W-1:0] h_eff;

    always_comb begin
        byp_eff = bypass || (div_n == '0);
        h_eff   = (high_cnt >= div_n) ? (div_n - CNT_ONE) : high_cnt;
        bnd     = !st_q.act || (st_q.cnt == st_q.n);
        st_d    = st_q;
        if (bnd) begin
            st_d.cnt = '0;
            if (go) begin
                st_d.act = 1'b1;
                st_d.byp = byp_eff;
                st_d.n   = byp_eff ? '0 : div_n;
                st_d.h   = byp_eff ? '0 : h_eff;
            end else begin
                st_d.act = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
        act_d = st_d.act;
        byp_d = st_d.byp;
        hi_d  = (st_d.cnt <= st_d.h);
        act_q = st_q.act;
        byp_q = st_q.byp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.cnt <= st_q.n)); // R1

    AST_HIGH_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !st_q.byp) |-> (st_q.h < st_q.n)); // R3

    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && (st_q.cnt != st_q.n)) |=>
            ($stable(st_q.n) && $stable(st_q.h) && $stable(st_q.byp))); // R8

endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_high,
    input  logic act_q,
    input  logic byp_q,
    input  logic act_d,
    input  logic byp_d,
    input  logic hi_d,
    output logic sclk,
    output logic launch_stb,
    output logic sample_stb
);

    line_st_t st_d, st_q;
    logic     burst;

    always_comb begin
        st_d.idle  = act_q ? st_q.idle : idle_high;
        st_d.sclk  = (act_d && !byp_d && hi_d) ? ~st_d.idle : st_d.idle;
        burst      = act_q && byp_q;
        sample_stb = burst ||
                     (act_d && !byp_d && (st_d.sclk != st_d.idle) && (st_q.sclk != st_d.sclk));
        launch_stb = burst ||
                     (act_q && !byp_q && (st_d.sclk == st_d.idle) && (st_q.sclk != st_d.sclk));
        sclk       = burst ? (clk ^ st_q.idle) : st_q.sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SAMPLE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !byp_q) |=> (st_q.sclk != st_q.idle)); // R5

    AST_LAUNCH_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_stb && !byp_q) |=> (st_q.sclk == st_q.idle)); // R5

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_q && !byp_d) |-> $onehot0({launch_stb, sample_stb})); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (st_q.sclk == st_q.idle)); // R6

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cs_active,
    input  logic [1:0]       tail_mode,
    input  logic [DIV_W-1:0] div_n,
    input  logic [DIV_W-1:0] high_cnt,
    input  logic             bypass,
    input  logic             idle_high,
    output logic             sclk,
    output logic             launch_stb,
    output logic             sample_stb
);

    localparam int TAIL_W = 2;

    logic go, bnd, act_q, byp_q, act_d, byp_d, hi_d;

    sclk_run_gate #(.TAIL_W(TAIL_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cs_active (cs_active),
        .tail_mode (tail_mode),
        .bnd       (bnd),
        .go        (go)
    );

    sclk_period_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .div_n    (div_n),
        .high_cnt (high_cnt),
        .bypass   (bypass),
        .bnd      (bnd),
        .act_q    (act_q),
        .byp_q    (byp_q),
        .act_d    (act_d),
        .byp_d    (byp_d),
        .hi_d     (hi_d)
    );

    sclk_edge_out u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_high  (idle_high),
        .act_q      (act_q),
        .byp_q      (byp_q),
        .act_d      (act_d),
        .byp_d      (byp_d),
        .hi_d       (hi_d),
        .sclk       (sclk),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !act_q) |=> !act_q); // R9

endmodule

// File: tb/sclk_gen_bench.sv
`timescale 1ns/1ps
module sclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n, enable, cs_active, bypass, idle_high;
    logic [1:0] tail_mode;
    logic [7:0] div_n, high_cnt;
    logic       sclk, launch_stb, sample_stb;

    int checks = 0;
    int fails  = 0;
    int mism   = 0;
    logic idl  = 1'b0;
    logic mon_en = 1'b0;

    always #2.5 clk = ~clk;

    sclk_gen u_sclk_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cs_active(cs_active),
        .tail_mode(tail_mode), .div_n(div_n), .high_cnt(high_cnt),
        .bypass(bypass), .idle_high(idle_high), .sclk(sclk),
        .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    // Strobe monitor: each strobe must announce the edge seen one cycle later (R5)
    logic m_prev = 1'b0, m_samp = 1'b0, m_launch = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (((m_prev == idl) && (sclk != idl)) != m_samp) mism++;
            if (((m_prev != idl) && (sclk == idl)) != m_launch) mism++;
        end
        m_prev   = sclk;
        m_samp   = sample_stb;
        m_launch = launch_stb;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int exp_high(input int n, input int h);
        return (h >= n) ? n : h + 1;
    endfunction

    task automatic wait_lead();
        logic prev = sclk;
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (prev == idl && sclk != idl) return;
            prev = sclk;
        end
    endtask

    task automatic count_from_edge(output int hi, output int per);
        logic prev = sclk;
        hi = 1; per = 1;
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (prev == idl && sclk != idl) return;
            per++;
            if (sclk != idl) hi++;
            prev = sclk;
        end
    endtask

    task automatic measure(output int hi, output int per);
        wait_lead();
        count_from_edge(hi, per);
    endtask

    task automatic count_leads(input int cyc, output int leads, output int actives);
        logic prev = sclk;
        leads = 0; actives = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (prev == idl && sclk != idl) leads++;
            if (sclk != idl) actives++;
            prev = sclk;
        end
    endtask

    task automatic bypass_check(input string req, input logic running);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(req, sclk, running ? !idl : idl);
            @(negedge clk); #1;
            chk(req, sclk, idl);
            chk(req, {sample_stb, launch_stb}, running ? 3 : 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int hi, per, leads, act, n, h;
        void'($urandom(32'd2024));
        rst_n = 0; enable = 0; cs_active = 0; tail_mode = 2'd0;
        div_n = 8'd3; high_cnt = 8'd1; bypass = 0; idle_high = 0;
        repeat (4) @(negedge clk);
        chk("R6 reset line", sclk, 0);
        chk("R6 reset strobes", {sample_stb, launch_stb}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R6 idle after reset", sclk, 0);
        mon_en = 1;
        enable = 1; cs_active = 1;

        // Directed N=3 H=1
        measure(hi, per); measure(hi, per);
        chk("R1 period n=3", per, 4);
        chk("R2 high n=3", hi, 2);

        // Random divide / high-time pairs
        for (int k = 0; k < 8; k++) begin
            n = 1 + int'($urandom % 12);
            h = int'($urandom % n);
            div_n = 8'(n); high_cnt = 8'(h);
            measure(hi, per); measure(hi, per);
            chk("R1 random period", per, n + 1);
            chk("R2 random high", hi, exp_high(n, h));
        end

        // Clamp of the high time
        div_n = 8'd5; high_cnt = 8'd9;
        measure(hi, per); measure(hi, per);
        chk("R3 clamp period", per, 6);
        chk("R3 clamp high", hi, exp_high(5, 9));
        div_n = 8'd4; high_cnt = 8'd4;
        measure(hi, per); measure(hi, per);
        chk("R3 equal high", hi, 4);

        // Settings change mid-period
        div_n = 8'd3; high_cnt = 8'd1;
        measure(hi, per);
        wait_lead();
        div_n = 8'd9; high_cnt = 8'd4;
        count_from_edge(hi, per);
        chk("R8 old period kept", per, 4);
        count_from_edge(hi, per);
        chk("R8 new period", per, 10);
        chk("R8 new high", hi, 5);

        // Tail policies after chip select drops
        div_n = 8'd3; high_cnt = 8'd1;
        for (int m = 0; m < 4; m++) begin
            tail_mode = 2'(m); cs_active = 1;
            measure(hi, per);
            wait_lead();
            cs_active = 0;
            count_leads(60, leads, act);
            if (m < 3) begin
                chk("R7 tail periods", leads, m);
                chk("R7 line idle after tail", sclk, idl);
            end else begin
                chk("R7 free run", (leads >= 14) ? 1 : 0, 1);
            end
        end
        cs_active = 1; tail_mode = 2'd3;

        // Enable drop: current period finishes, none start
        measure(hi, per);
        wait_lead();
        enable = 0;
        count_leads(40, leads, act);
        chk("R9 no new period", leads, 0);
        chk("R9 period completes", act, 1);
        chk("R9 stopped strobes", {sample_stb, launch_stb}, 0);
        chk("R5 strobe alignment", mism, 0);

        // Idle level high
        mon_en = 0;
        idle_high = 1; idl = 1;
        repeat (3) @(negedge clk);
        chk("R6 idle high level", sclk, 1);
        mon_en = 1;
        enable = 1;
        measure(hi, per); measure(hi, per);
        chk("R2 high with idle high", hi, 2);
        chk("R1 period with idle high", per, 4);
        chk("R5 strobe alignment idle high", mism, 0);
        enable = 0;
        repeat (10) @(negedge clk);
        mon_en = 0;
        idle_high = 0; idl = 0;
        repeat (3) @(negedge clk);
        chk("R6 idle back low", sclk, 0);

        // Pass-through via bypass bit
        bypass = 1; enable = 1; cs_active = 1; tail_mode = 2'd0;
        repeat (10) @(negedge clk);
        bypass_check("R4 bypass bit", 1'b1);
        // Pass-through via zero divide
        bypass = 0; div_n = 8'd0;
        repeat (10) @(negedge clk);
        bypass_check("R4 zero divide", 1'b1);
        cs_active = 0;
        repeat (10) @(negedge clk);
        bypass_check("R4 pass-through stopped", 1'b0);
        // Pass-through with idle high
        idle_high = 1; idl = 1;
        repeat (3) @(negedge clk);
        cs_active = 1;
        repeat (10) @(negedge clk);
        bypass_check("R4 pass-through idle high", 1'b1);

        finish_run();
    end

endmodule